// File: doc/BRIEF.md
# TLB Invalidate Request Controller

This block turns a one-cycle request naming a client engine into a translation-cache invalidate command for a memory management unit, then watches that command until it completes. It writes a command word into a single control register through a one-cycle write port. It then reads the same register back, one read at a time, until the start bit has dropped. A read may take any fixed number of cycles to return; the block waits for the read-valid strobe before it looks at the data.

Completion is reported upstream as a one-cycle `done` pulse. If the start bit is still set when the poll budget runs out, `err` pulses in the same cycle as `done`, and `rsp_engine` names the engine that timed out. A full flush request first asks the instance-memory write path to drain and waits for its acknowledge. Only then does it issue the invalidate, always for the host engine. The block takes one request at a time and queues nothing.

Top module: `tlbinv_ctrl`

## Requirements
- R1: The command word written has bit 0 set to 1, the engine number in bits [ENG_LSB+EW-1:ENG_LSB] (default bits 23:16), and all other bits 0. Engine 0x0A therefore writes 0x000A0001.
- R2: Each accepted request causes exactly one single-cycle register write. After it, single-cycle reads are issued with at most one read outstanding, and a new read is issued only after the previous read's valid strobe.
- R3: When a returned read has bit 0 equal to 0, `done` pulses for exactly one cycle with `err` low. The other bits of the read data are ignored, so success after N reads returning 1 takes N+1 reads.
- R4: If bit 0 has not read back 0 by TIMEOUT_CYC cycles after the write, `done` and `err` pulse together for one cycle, and `rsp_engine` carries the engine of that request.
- R5: `busy` is high from the cycle after a request is accepted through the `done` cycle. A request presented while `busy` is high is dropped: it causes no register write, either then or later.
- R6: A request with `req_full` high raises `wpf_req` and holds it until `wpf_ack`. No register write happens before the acknowledge. The invalidate then targets engine FULL_ENG (default 6), whatever `req_engine` was.
- R7: The timeout budget restarts for every request, so back-to-back timed-out requests each take at least TIMEOUT_CYC+1 cycles from write to `done`.
- R8: After reset, `busy`, `done`, `err`, `wpf_req`, `reg_wr_en` and `reg_rd_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_engine | input | EW | Client engine to invalidate |
| req_full | input | 1 | Full flush: drain write path, then invalidate the host engine |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout, pulses together with done |
| rsp_engine | output | EW | Engine of the finishing request, valid with done |
| wpf_req | output | 1 | Write-path flush request, held until acknowledged |
| wpf_ack | input | 1 | Write-path flush acknowledge |
| reg_wr_en | output | 1 | Control register write strobe |
| reg_wr_data | output | DW | Command word |
| reg_rd_en | output | 1 | Control register read strobe |
| reg_rd_valid | input | 1 | Read data valid, a fixed latency after reg_rd_en |
| reg_rd_data | input | DW | Control register read data; only bit 0 is used |

## Verification
The assertions assume that `wpf_ack` is only given while `wpf_req` is high. They also assume that `reg_rd_valid` answers each read strobe exactly once, after a fixed latency. The bench's register model meets both assumptions. It delays every read by a two-stage pipeline, and it drives the acknowledge only after it has seen `wpf_req`. The model also sets every bit of the read data above bit 0 to 1, so any decoding of bits other than the start bit shows up as a failure.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_WPF,
      S_WRITE,
      S_READ,
      S_WAIT,
      S_OK,
      S_ERR
   } tlbinv_state_e;
endpackage

// File: rtl/tlbinv_cmd_enc.sv
module tlbinv_cmd_enc #(
   parameter int DW      = 32,
   parameter int EW      = 8,
   parameter int ENG_LSB = 16
) (
   input  logic [EW-1:0] eng,
   output logic [DW-1:0] cmd
);
   localparam int ENG_MSB = ENG_LSB + EW - 1;

   // bit 0 is the start/trigger bit, engine field sits above it
   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (b == 0) begin : g_start
         assign cmd[b] = 1'b1;
      end else if (b >= ENG_LSB && b <= ENG_MSB) begin : g_eng
         assign cmd[b] = eng[b-ENG_LSB];
      end else begin : g_zero
         assign cmd[b] = 1'b0;
      end
   end
endmodule

// File: rtl/tlbinv_poll_timer.sv
module tlbinv_poll_timer #(
   parameter int LIMIT = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (!run)      cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == LIM);

   // R7: once expired, the budget stays spent while the poll runs
   a_r7_expiry_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      expired && run |=> expired);
endmodule

// File: rtl/tlbinv_fsm.sv
module tlbinv_fsm
   import tlbinv_pkg::*;
#(
   parameter int EW       = 8,
   parameter int FULL_ENG = 6,
   parameter bit HAS_WPF  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [EW-1:0] req_engine,
   input  logic          req_full,
   input  logic          wpf_ack,
   input  logic          rd_valid,
   input  logic          rd_bit0,
   input  logic          expired,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [EW-1:0] eng_q,
   output logic          wpf_req,
   output logic          wr_en,
   output logic          rd_en,
   output logic          timer_run
);
   localparam logic [EW-1:0] HOST_ENG = EW'(FULL_ENG);

   tlbinv_state_e state, state_n;
   logic          rd_pend;
   logic          full_go;

   if (HAS_WPF) begin : g_wpf
      assign full_go = req_full;
   end else begin : g_nowpf
      logic full_unused;
      assign full_unused = req_full;
      assign full_go     = 1'b0;
   end

   always_comb begin
      state_n = state;
      unique case (state)
         S_IDLE:  if (req_valid) state_n = full_go ? S_WPF : S_WRITE;
         S_WPF:   if (wpf_ack) state_n = S_WRITE;
         S_WRITE: state_n = S_READ;
         S_READ:  if (!rd_pend) state_n = S_WAIT;
         S_WAIT: begin
            if (rd_valid && !rd_bit0) state_n = S_OK;
            else if (expired)         state_n = S_ERR;
            else if (rd_valid)        state_n = S_READ;
         end
         S_OK, S_ERR: state_n = S_IDLE;
         default:     state_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         eng_q   <= '0;
         rd_pend <= 1'b0;
      end else begin
         state   <= state_n;
         rd_pend <= rd_en | (rd_pend & ~rd_valid);
         if (state == S_IDLE && req_valid)
            eng_q <= full_go ? HOST_ENG : req_engine;
      end
   end

   assign busy      = (state != S_IDLE);
   assign done      = (state == S_OK) || (state == S_ERR);
   assign err       = (state == S_ERR);
   assign wpf_req   = (state == S_WPF);
   assign wr_en     = (state == S_WRITE);
   assign rd_en     = (state == S_READ) && !rd_pend;
   assign timer_run = (state == S_WRITE) || (state == S_READ) || (state == S_WAIT);

   // R2: strobes are single-cycle
   a_r2_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
   a_r2_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);
   // R3: done is a one-cycle pulse
   a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4: an error is only reported once the poll budget had run out
   a_r4_err_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(expired));
   // R5: any downstream activity happens while busy
   a_r5_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || rd_en || wpf_req) |-> busy);
   // R6: write-path flush request holds, and no write precedes the ack
   a_r6_wpf_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wpf_req && !wpf_ack |=> wpf_req && !wr_en);
endmodule

// File: rtl/tlbinv_ctrl.sv
module tlbinv_ctrl #(
   parameter int DW          = 32,
   parameter int EW          = 8,
   parameter int ENG_LSB     = 16,
   parameter int TIMEOUT_CYC = 2000,
   parameter int FULL_ENG    = 6,
   parameter bit HAS_WPF     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [EW-1:0] req_engine,
   input  logic          req_full,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic [EW-1:0] rsp_engine,
   output logic          wpf_req,
   input  logic          wpf_ack,
   output logic          reg_wr_en,
   output logic [DW-1:0] reg_wr_data,
   output logic          reg_rd_en,
   input  logic          reg_rd_valid,
   input  logic [DW-1:0] reg_rd_data
);
   if (ENG_LSB < 1 || ENG_LSB + EW > DW) begin : g_bad_field
      $error("engine field does not fit the command word");
   end
   if (TIMEOUT_CYC < 1) begin : g_bad_timeout
      $error("TIMEOUT_CYC must be at least 1");
   end
   if (FULL_ENG < 0 || FULL_ENG >= (1 << EW)) begin : g_bad_host
      $error("FULL_ENG does not fit EW bits");
   end

   logic          expired, timer_run;
   logic [EW-1:0] eng_q;
   logic          rd_unused;

   assign rd_unused = ^reg_rd_data[DW-1:1];

   tlbinv_fsm #(
      .EW       (EW),
      .FULL_ENG (FULL_ENG),
      .HAS_WPF  (HAS_WPF)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_engine (req_engine),
      .req_full   (req_full),
      .wpf_ack    (wpf_ack),
      .rd_valid   (reg_rd_valid),
      .rd_bit0    (reg_rd_data[0]),
      .expired    (expired),
      .busy       (busy),
      .done       (done),
      .err        (err),
      .eng_q      (eng_q),
      .wpf_req    (wpf_req),
      .wr_en      (reg_wr_en),
      .rd_en      (reg_rd_en),
      .timer_run  (timer_run)
   );

   tlbinv_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (timer_run),
      .expired (expired)
   );

   tlbinv_cmd_enc #(.DW(DW), .EW(EW), .ENG_LSB(ENG_LSB)) u_enc (
      .eng (eng_q),
      .cmd (reg_wr_data)
   );

   assign rsp_engine = eng_q;

   // R1: every write carries the start bit
   a_r1_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> reg_wr_data[0]);
endmodule

// File: tb/tlbinv_ctrl_tb.sv
module tlbinv_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32, EW = 8, T = 40, RDLAT = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_full = 1'b0, wpf_ack = 1'b0;
   logic [EW-1:0] req_engine = '0;
   logic busy, done, err, wpf_req, reg_wr_en, reg_rd_en, reg_rd_valid;
   logic [EW-1:0] rsp_engine;
   logic [DW-1:0] reg_wr_data, reg_rd_data;

   int total = 0, bad = 0;
   int cfg_polls = 0;
   bit never_clear = 1'b0;

   // register model state
   int cyc = 0, wr_cnt = 0, wr_cyc = 0, rd_cnt = 0;
   logic [DW-1:0] last_wr = '0;
   logic [RDLAT-1:0] vpipe = '0, dpipe = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlbinv_ctrl #(.DW(DW), .EW(EW), .TIMEOUT_CYC(T)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_engine(req_engine),
      .req_full(req_full), .busy(busy), .done(done), .err(err),
      .rsp_engine(rsp_engine), .wpf_req(wpf_req), .wpf_ack(wpf_ack),
      .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
      .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data));

   assign reg_rd_valid = vpipe[RDLAT-1];
   assign reg_rd_data  = {{(DW-1){1'b1}}, dpipe[RDLAT-1]};

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         wr_cnt <= 0; rd_cnt <= 0; vpipe <= '0; dpipe <= '0;
      end else begin
         if (reg_wr_en) begin
            wr_cnt <= wr_cnt + 1; last_wr <= reg_wr_data; wr_cyc <= cyc; rd_cnt <= 0;
         end
         vpipe <= {vpipe[RDLAT-2:0], reg_rd_en};
         dpipe <= {dpipe[RDLAT-2:0], never_clear || (rd_cnt < cfg_polls)};
         if (reg_rd_en) rd_cnt <= rd_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [EW-1:0] eng, input bit full);
      @(negedge clk);
      req_valid = 1'b1; req_engine = eng; req_full = full;
      @(negedge clk);
      req_valid = 1'b0; req_full = 1'b0;
   endtask

   // waits at negedges for done; returns 0 if it never came
   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 500 && !seen; i++) begin
         if (done) seen = 1'b1;
         else @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk(!busy && !done && !err && !wpf_req && !reg_wr_en && !reg_rd_en,
          "R8 reset outputs", {busy, done, err, wpf_req, reg_wr_en, reg_rd_en}, 0);
   endtask

   task automatic t_engine(input logic [EW-1:0] eng, input int polls);
      bit seen;
      int w0;
      w0 = wr_cnt; cfg_polls = polls; never_clear = 1'b0;
      send(eng, 1'b0);
      wait_done(seen);
      chk(seen, "R3 done seen", seen, 1);
      chk(!err, "R3 no err on success", err, 0);
      chk(last_wr == ((DW'(eng) << 16) | 32'h1), "R1 command word", last_wr,
          (DW'(eng) << 16) | 32'h1);
      chk(wr_cnt == w0 + 1, "R2 one write", wr_cnt - w0, 1);
      chk(rd_cnt == polls + 1, "R3 read count", rd_cnt, polls + 1);
      @(negedge clk);
      chk(!done && !busy, "R3 done one cycle", {done, busy}, 0);
   endtask

   task automatic t_timeout(input logic [EW-1:0] eng);
      bit seen;
      int d;
      never_clear = 1'b1;
      send(eng, 1'b0);
      wait_done(seen);
      d = cyc - wr_cyc;
      chk(seen && err, "R4 timeout err with done", {seen, err}, 3);
      chk(rsp_engine == eng, "R4 engine tag", rsp_engine, eng);
      chk(d >= T + 1 && d <= T + 3, "R7 full budget per request", d, T + 1);
      @(negedge clk);
      chk(!done && !err, "R4 pulse one cycle", {done, err}, 0);
      never_clear = 1'b0;
      repeat (RDLAT + 2) @(negedge clk);
   endtask

   task automatic t_busy_reject;
      bit seen;
      int w0;
      w0 = wr_cnt; cfg_polls = 4; never_clear = 1'b0;
      send(8'h05, 1'b0);
      @(negedge clk);
      chk(busy, "R5 busy during flush", busy, 1);
      send(8'h0A, 1'b0);
      wait_done(seen);
      chk(last_wr == 32'h0005_0001, "R5 first request kept", last_wr, 32'h0005_0001);
      repeat (8) @(negedge clk);
      chk(wr_cnt == w0 + 1, "R5 second request dropped", wr_cnt - w0, 1);
      chk(!busy, "R5 idle after done", busy, 0);
   endtask

   task automatic t_full_flush;
      bit seen;
      int w0;
      w0 = wr_cnt; cfg_polls = 1;
      send(8'h03, 1'b1);
      repeat (5) @(negedge clk);
      chk(wpf_req, "R6 wpf_req held", wpf_req, 1);
      chk(wr_cnt == w0, "R6 no write before ack", wr_cnt - w0, 0);
      wpf_ack = 1'b1;
      @(negedge clk);
      wpf_ack = 1'b0;
      wait_done(seen);
      chk(seen && !err, "R6 full flush completes", {seen, err}, 2);
      chk(last_wr == 32'h0006_0001, "R6 host engine used", last_wr, 32'h0006_0001);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++; total++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_engine(8'h00, 0);
      t_engine(8'h05, 3);
      t_engine(8'h06, 1);
      t_engine(8'h0A, 6);
      t_timeout(8'h0A);
      t_timeout(8'h00);
      t_busy_reject;
      t_full_flush;
      t_engine(8'hFF, 2);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule